// File: doc/BRIEF.md
# Symmetric-Coefficient FIR Band Filter

This block filters a stream of signed 16-bit audio samples through a 31-tap linear-phase FIR whose impulse response is mirror-symmetric. Because tap k and tap 30−k share a value, only 16 coefficients are held. For each output, the two samples that meet the same coefficient are added before the multiply. One time-shared multiply-accumulate unit therefore needs 16 products per output instead of 31.

Every accepted sample is divided by four with an arithmetic right shift before it enters a 31-entry window. The window holds the newest sample and the 30 before it. The window is never flushed at a frame boundary, so the history flows from one 80-sample frame into the next. A frame counter marks every 80th output.

Samples enter on a valid/ready handshake, and one filtered sample leaves for each sample accepted. Coefficients are written through an index/data/write-enable port. A clear input restarts the history and the frame count when one independent stream ends and another begins.

Top module: `sym_fir_filter`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o and frame_done_o are 0, and the sample history and all 16 coefficients are zero.
- R2: Each accepted sample is arithmetically shifted right by 2 before it is stored. For example, -1 stays -1, 3 becomes 0 and 32767 becomes 8191.
- R3: Let w[30] be the newest stored sample and w[0] the one accepted 30 samples earlier. The accumulator is then the sum, for k = 0 to 14, of c[k]·(w[k]+w[30−k]), plus c[15]·w[15], where c[k] is the coefficient at index k.
- R4: The accumulator is 32 bits wide and wraps on overflow. out_data_o holds the low 16 bits of (accumulator + 0x4000) shifted arithmetically right by 15, with no saturation.
- R5: out_valid_o rises 16 clock edges after the edge that accepts a sample. in_ready_o stays low from the accepting edge until out_valid_o is high.
- R6: Each accepted sample produces exactly one out_valid_o pulse, and that pulse lasts one cycle.
- R7: History carries across frame boundaries. The first output of a frame depends on the last 30 samples of the previous frame.
- R8: frame_done_o is high together with out_valid_o on every 80th output counted since reset or the last clear. At all other times it is low.
- R9: While the filter is idle, clear_hist_i zeroes the history and the frame count. in_ready_o is low while clear_hist_i is high.
- R10: clear_hist_i has no effect while a sample is being computed.
- R11: A write to coefficient index 0 to 15 while the filter is idle applies to the next sample. A write while a sample is being computed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_hist_i | input | 1 | Zero the history and frame count (idle only) |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 4 | Coefficient index 0..15 |
| coef_data_i | input | 16 | Signed coefficient value |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 16 | Signed input sample |
| in_ready_o | output | 1 | Filter can accept a sample |
| out_valid_o | output | 1 | One-cycle pulse with each filtered sample |
| out_data_o | output | 16 | Signed filtered sample |
| frame_done_o | output | 1 | Marks the 80th output of a frame |

## Verification
The hardest situations to reach from the ports are a clear or a coefficient write that lands inside the 16-cycle computation window, and an accumulator that wraps past 32 bits. The bench reaches the first by raising clear_hist_i or coef_we_i on the cycle right after a sample is accepted. The outputs that follow must then still match a model that ignored those pulses. It reaches the second by loading every coefficient with 32767 and driving full-scale samples, so that the unsaturated wrap shows up in out_data_o. A run of 170 samples after a clear crosses two frame boundaries, which exercises both the carried history and the timing of frame_done_o.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} sfir_state_e;
endpackage

// File: rtl/sfir_hist.sv
module sfir_hist #(
  parameter int DATA_W    = 16,
  parameter int NUM_TAPS  = 31,
  parameter int PRE_SHIFT = 2,
  parameter int SEL_W     = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     push_i,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic signed [DATA_W-1:0] near_o,
  output logic signed [DATA_W-1:0] far_o
);
  localparam int IDX_W = $clog2(NUM_TAPS);
  localparam int MID   = (NUM_TAPS - 1) / 2;

  logic signed [DATA_W-1:0] win_q [NUM_TAPS];
  logic signed [DATA_W-1:0] din_scaled;
  logic [IDX_W-1:0]         near_idx, far_idx;

  assign din_scaled = din_i >>> PRE_SHIFT;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic signed [DATA_W-1:0] nxt;
    if (t == NUM_TAPS - 1) begin : g_head
      assign nxt = din_scaled;
    end else begin : g_body
      assign nxt = win_q[t+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      win_q[t] <= '0;
      else if (clear_i) win_q[t] <= '0;
      else if (push_i)  win_q[t] <= nxt;
    end
  end

  always_comb begin
    near_idx = IDX_W'(sel_i);
    far_idx  = IDX_W'(NUM_TAPS - 1) - near_idx;
    near_o   = win_q[near_idx];
    // middle tap has no partner
    far_o    = (near_idx == IDX_W'(MID)) ? '0 : win_q[far_idx];
  end
endmodule

// File: rtl/sfir_coef_bank.sv
module sfir_coef_bank #(
  parameter int DATA_W   = 16,
  parameter int NUM_COEF = 16,
  parameter int SEL_W    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SEL_W-1:0]         waddr_i,
  input  logic signed [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic signed [DATA_W-1:0] coef_o
);
  logic signed [DATA_W-1:0] coef_q [NUM_COEF];

  for (genvar c = 0; c < NUM_COEF; c++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                coef_q[c] <= '0;
      else if (we_i && waddr_i == SEL_W'(c))      coef_q[c] <= wdata_i;
    end
  end

  assign coef_o = coef_q[sel_i];
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int DATA_W      = 16,
  parameter int ACC_W       = 32,
  parameter int ROUND_SHIFT = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     en_i,
  input  logic                     last_i,
  input  logic signed [DATA_W-1:0] near_i,
  input  logic signed [DATA_W-1:0] far_i,
  input  logic signed [DATA_W-1:0] coef_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_data_o
);
  localparam int RND = 1 << (ROUND_SHIFT - 1);

  logic signed [DATA_W-1:0] pre_sum;
  logic signed [ACC_W-1:0]  pre_x, coef_x, prod, acc_q, acc_sum, rnd_sum;

  always_comb begin
    pre_sum = near_i + far_i;  // fits: operands are pre-shifted
    pre_x   = ACC_W'(pre_sum);
    coef_x  = ACC_W'(coef_i);
    prod    = pre_x * coef_x;
    acc_sum = acc_q + prod;
    rnd_sum = acc_sum + ACC_W'(RND);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= en_i && last_i;
      if (start_i)   acc_q <= '0;
      else if (en_i) acc_q <= acc_sum;
      if (en_i && last_i) out_data_o <= DATA_W'(rnd_sum >>> ROUND_SHIFT);
    end
  end
endmodule

// File: rtl/sfir_ctrl.sv
module sfir_ctrl import sfir_pkg::*; #(
  parameter int NUM_COEF  = 16,
  parameter int FRAME_LEN = 80,
  parameter int SEL_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             clear_i,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic             hist_clr_o,
  output logic             idle_o,
  output logic             mac_en_o,
  output logic             last_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             frame_done_o
);
  localparam int FCNT_W = $clog2(FRAME_LEN);
  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(NUM_COEF - 1);
  localparam logic [FCNT_W-1:0] LAST_FRM  = FCNT_W'(FRAME_LEN - 1);

  sfir_state_e       state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [FCNT_W-1:0] frame_q;
  logic              frame_end;

  assign idle_o     = (state_q == ST_IDLE);
  assign in_ready_o = idle_o && !clear_i;
  assign accept_o   = in_ready_o && in_valid_i;
  assign hist_clr_o = idle_o && clear_i;
  assign mac_en_o   = !idle_o;
  assign last_o     = !idle_o && (sel_q == LAST_SEL);
  assign sel_o      = sel_q;
  assign frame_end  = (frame_q == LAST_FRM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sel_q        <= '0;
      frame_q      <= '0;
      frame_done_o <= 1'b0;
    end else begin
      frame_done_o <= last_o && frame_end;
      case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_BUSY;
          sel_q   <= '0;
        end
        default: begin
          if (last_o) state_q <= ST_IDLE;
          else        sel_q   <= sel_q + 1'b1;
        end
      endcase
      if (hist_clr_o)  frame_q <= '0;
      else if (last_o) frame_q <= frame_end ? '0 : frame_q + 1'b1;
    end
  end
endmodule

// File: rtl/sym_fir_filter.sv
module sym_fir_filter #(
  parameter int DATA_W      = 16,
  parameter int NUM_TAPS    = 31,
  parameter int FRAME_LEN   = 80,
  parameter int PRE_SHIFT   = 2,
  parameter int ROUND_SHIFT = 15,
  parameter int ACC_W       = 32,
  localparam int NUM_COEF   = (NUM_TAPS + 1) / 2,
  localparam int SEL_W      = $clog2(NUM_COEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_hist_i,
  input  logic              coef_we_i,
  input  logic [SEL_W-1:0]  coef_addr_i,
  input  logic [DATA_W-1:0] coef_data_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              frame_done_o
);
  logic accept, hist_clr, idle, mac_en, last;
  logic [SEL_W-1:0] sel;
  logic signed [DATA_W-1:0] near_s, far_s, coef_s, out_s;

  sfir_ctrl #(.NUM_COEF(NUM_COEF), .FRAME_LEN(FRAME_LEN), .SEL_W(SEL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .in_valid_i   (in_valid_i),
    .clear_i      (clear_hist_i),
    .in_ready_o   (in_ready_o),
    .accept_o     (accept),
    .hist_clr_o   (hist_clr),
    .idle_o       (idle),
    .mac_en_o     (mac_en),
    .last_o       (last),
    .sel_o        (sel),
    .frame_done_o (frame_done_o)
  );

  sfir_hist #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .PRE_SHIFT(PRE_SHIFT), .SEL_W(SEL_W)) u_hist (
    .clk_i, .rst_ni,
    .clear_i (hist_clr),
    .push_i  (accept),
    .din_i   ($signed(in_data_i)),
    .sel_i   (sel),
    .near_o  (near_s),
    .far_o   (far_s)
  );

  sfir_coef_bank #(.DATA_W(DATA_W), .NUM_COEF(NUM_COEF), .SEL_W(SEL_W)) u_coef (
    .clk_i, .rst_ni,
    .we_i    (coef_we_i && idle),
    .waddr_i (coef_addr_i),
    .wdata_i ($signed(coef_data_i)),
    .sel_i   (sel),
    .coef_o  (coef_s)
  );

  sfir_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ROUND_SHIFT(ROUND_SHIFT)) u_mac (
    .clk_i, .rst_ni,
    .start_i     (accept),
    .en_i        (mac_en),
    .last_i      (last),
    .near_i      (near_s),
    .far_i       (far_s),
    .coef_i      (coef_s),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_s)
  );

  assign out_data_o = out_s;
endmodule

// File: rtl/sfir_checker.sv
module sfir_checker #(
  parameter int NUM_TAPS = 31
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_hist_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic frame_done_o
);
  localparam int LAT = (NUM_TAPS + 1) / 2;

  logic accept;
  logic [7:0] lat_cnt;
  assign accept = in_valid_i && in_ready_o;

  // counts edges including the accepting one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lat_cnt <= '0;
    else if (accept)          lat_cnt <= 8'd1;
    else if (out_valid_o)     lat_cnt <= '0;
    else if (lat_cnt != 8'd0) lat_cnt <= lat_cnt + 8'd1;
  end

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> lat_cnt == 8'(LAT + 1));
  a_r5_ready_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_cnt != 8'd0 && !out_valid_o) |-> !in_ready_o);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  a_r8_done_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> out_valid_o);
  a_r9_no_ready_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_hist_i |-> !in_ready_o);
endmodule

bind sym_fir_filter sfir_checker u_sfir_checker (
  .clk_i, .rst_ni, .clear_hist_i, .in_valid_i,
  .in_ready_o, .out_valid_o, .frame_done_o
);

// File: tb/sym_fir_filter_test.sv
`timescale 1ns/1ps
module sym_fir_filter_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        clear_hist = 1'b0, coef_we = 1'b0, in_valid = 1'b0;
  logic [3:0]  coef_addr = '0;
  logic [15:0] coef_data = '0, in_data = '0;
  logic        in_ready, out_valid, frame_done;
  logic [15:0] out_data;

  int n_checks = 0, n_fail = 0;
  int hist [31];
  int coef [16];
  int frame_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sym_fir_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_hist_i(clear_hist),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .frame_done_o(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_push(input logic [15:0] s);
    int acc = 0;
    int sv = int'($signed(s));
    for (int t = 0; t < 30; t++) hist[t] = hist[t+1];
    hist[30] = sv >>> 2;
    for (int k = 0; k < 15; k++) acc += coef[k] * (hist[k] + hist[30-k]);
    acc += coef[15] * hist[15];
    acc = (acc + 32'h4000) >>> 15;
    return acc[15:0];
  endfunction

  task automatic write_coef(input int a, input int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = 16'(d);
    @(negedge clk);
    coef_we = 1'b0;
    coef[a] = int'($signed(16'(d)));
  endtask

  task automatic clear_idle();
    @(negedge clk);
    clear_hist = 1'b1;
    #1 check(in_ready == 1'b0, "R9 ready low on clear", int'(in_ready), 0);
    @(negedge clk);
    clear_hist = 1'b0;
    foreach (hist[t]) hist[t] = 0;
    frame_cnt = 0;
  endtask

  // side: 0 none, 1 clear pulse while busy, 2 coef write while busy
  task automatic send(input logic [15:0] s, input int side, input string req);
    int cnt;
    logic [15:0] exp;
    bit exp_done;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = s;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R5 ready low while busy", int'(in_ready), 0);
    if (side == 1) clear_hist = 1'b1;
    if (side == 2) begin coef_we = 1'b1; coef_addr = 4'd0; coef_data = 16'd12345; end
    cnt = 1;
    exp = model_push(s);
    exp_done = (frame_cnt == 79);
    frame_cnt = (frame_cnt + 1) % 80;
    do begin
      @(negedge clk);
      clear_hist = 1'b0; coef_we = 1'b0;
      cnt++;
    end while (!out_valid && cnt < 40);
    check(cnt == 17, "R5 latency 16 edges", cnt - 1, 16);
    check(out_data == exp, req, int'($signed(out_data)), int'($signed(exp)));
    check(frame_done == exp_done, "R8 frame_done", int'(frame_done), int'(exp_done));
    @(negedge clk);
    check(out_valid == 1'b0, "R6 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    #1 check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 no valid after reset", int'(out_valid), 0);
    check(frame_done == 1'b0, "R1 no frame_done after reset", int'(frame_done), 0);
    send(16'd20000, 0, "R1 zero coefficients give zero");
  endtask

  task automatic t_shift();
    for (int k = 0; k < 16; k++) write_coef(k, (k + 1) * 613 - 4100);
    write_coef(15, 16384);
    clear_idle();
    send(16'hFFFF, 0, "R2 shift of -1");
    send(16'd3, 0, "R2 shift of 3");
    send(16'd32767, 0, "R2 shift of 32767");
    send(16'h8000, 0, "R2 shift of -32768");
  endtask

  task automatic t_fold();
    for (int i = 0; i < 40; i++) send(16'($urandom), 0, "R3 folded sum");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 16; k++) write_coef(k, 32767);
    for (int i = 0; i < 31; i++) send(16'd32767, 0, "R4 wrap, no saturation");
    for (int i = 0; i < 31; i++) send(16'h8000, 0, "R4 negative full scale");
  endtask

  task automatic t_frames();
    for (int k = 0; k < 16; k++) write_coef(k, 1000 - k * 140);
    clear_idle();
    for (int i = 0; i < 170; i++) send(16'($urandom), 0, "R7 history across frames");
  endtask

  task automatic t_ctrl_busy();
    clear_idle();
    for (int i = 0; i < 5; i++) send(16'($urandom), 0, "R9 after idle clear");
    send(16'd7000, 1, "R10 busy clear ignored");
    send(16'd5000, 0, "R10 history kept");
    send(16'd9000, 2, "R11 busy write ignored");
    send(16'd9000, 0, "R11 coef unchanged");
    write_coef(0, -20000);
    send(16'd9000, 0, "R11 idle write applies");
  endtask

  initial begin
    foreach (hist[t]) hist[t] = 0;
    foreach (coef[k]) coef[k] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_shift();
    t_fold();
    t_wrap();
    t_frames();
    t_ctrl_busy();
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule